// File: doc/BRIEF.md
# Multiplexed LCD Drive-Level Sequencer

This block produces, for a passive multiplexed liquid-crystal panel, a symbolic drive-level code for every common line and every segment line. A frame-clock tick from an external prescaler moves a phase counter forward. The current phase picks the one common line that is active, and a frame-parity bit alternates polarity frame by frame so the glass never sees a net DC voltage. Each segment line is driven either opposite to the active common, which lights the pixel, or to a dark level.

The configuration inputs are a duty selection (static, 1/2, 1/3, 1/4 or 1/8), a bias selection (1/2, 1/3 or 1/4), an enable, and a flat pixel array indexed by common and segment. The level codes go to an analog ladder outside this block, which turns them into real voltages. A status output reports whether the sequencer is running.

Top module: `lcd_mux_drive`

## Requirements
- R1: After synchronous reset, every common and segment code is 0 (ground) and `en_stat` is 0.
- R2: When `en` is low at a clock edge, every common and segment code is 0 after that edge and the phase state restarts. `en_stat` is 0 in every cycle in which `en` is low.
- R3: With `en` high, `en_stat` goes to 1 after the first edge where `phase_tick` is high. That first tick shows phase 0 of an odd frame.
- R4: Level codes are 3 bits wide: 0 ground, 1 quarter, 2 third, 3 half, 4 two-thirds, 5 three-quarters, 6 full. No other code ever appears. With `en` high, the codes change only at an edge where `phase_tick` is high.
- R5: The common line whose index equals the phase drives 6 in odd frames and 0 in even frames. At most one common line drives 6 at any time.
- R6: A used common line that is not active drives 3 under 1/2 bias. Under 1/3 bias it drives 2 in odd frames and 4 in even frames. Under 1/4 bias it drives 1 in odd frames and 5 in even frames. `bias_sel` is encoded 0 = 1/2, 1 = 1/3, and 2 or 3 = 1/4.
- R7: Common lines whose index is at or above the number of phases in the frame drive 0. Under static duty this covers lines 7 down to 1.
- R8: `duty_sel` is encoded 0 = static (1 phase), 1 = 2 phases, 2 = 3 phases, 3 = 4 phases, and 4 to 7 = 8 phases. Each tick advances the phase by one. The phase wraps to 0 after the last phase, and the frame parity toggles on each wrap. Under static duty it therefore toggles on every tick.
- R9: A lit pixel drives its segment to 0 in odd frames and to 6 in even frames. Pixel bit index = common*NUM_SEG + segment, and the row used is the one for the active phase.
- R10: A dark pixel under static duty drives its segment equal to common 0 (6 in odd frames, 0 in even frames). When multiplexed, a dark segment drives 3 under 1/2 bias, 4 in odd frames and 2 in even frames under 1/3 bias, and 3 under 1/4 bias.
- R11: A change of `duty_sel` or `bias_sel` while running takes effect only at the next frame boundary (phase wrap) or at the next start from disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable for the sequencer |
| phase_tick | input | 1 | Single-cycle frame-clock tick that advances the phase |
| duty_sel | input | 3 | Duty selection |
| bias_sel | input | 2 | Bias selection |
| pix | input | 8*NUM_SEG | Pixel bits, index common*NUM_SEG+segment |
| com_lvl | output | 24 | 3-bit level code per common line, line c at bits [3c+2:3c] |
| seg_lvl | output | 3*NUM_SEG | 3-bit level code per segment line |
| en_stat | output | 1 | Running status |

## Verification
A wrong phase count or a missed wrap puts the full-level code on the wrong common line at the very next tick. A parity error swaps full and ground on the active line and inverts the inactive pair on every other line. Both show at the ports one cycle after the offending tick. A configuration that is latched at the wrong moment shows up as wrong inactive levels, or as a wrong number of used common lines, within the frame that follows the change. The bench runs a model of phase, parity and latched configuration beside the design and compares every line after every edge.

// File: rtl/lcd_lvl_pkg.sv
package lcd_lvl_pkg;

    localparam int COM_MAX = 8;
    localparam int LVL_W   = 3;
    localparam int PH_W    = $clog2(COM_MAX);
    localparam int NPH_W   = PH_W + 1;

    typedef enum logic [LVL_W-1:0] {
        LV_GND  = 3'd0,
        LV_Q1   = 3'd1,
        LV_T1   = 3'd2,
        LV_HALF = 3'd3,
        LV_T2   = 3'd4,
        LV_Q3   = 3'd5,
        LV_FULL = 3'd6
    } lvl_e;

    typedef enum logic [1:0] {
        BIAS_2 = 2'd0,
        BIAS_3 = 2'd1,
        BIAS_4 = 2'd2
    } bias_e;

    typedef struct packed {
        logic [PH_W-1:0]  phase;
        logic             odd;
        logic [NPH_W-1:0] nph;
        bias_e            bias;
    } drv_ctx_t;

    function automatic logic [NPH_W-1:0] duty_phases(logic [2:0] d);
        case (d)
            3'd0:    return NPH_W'(1);
            3'd1:    return NPH_W'(2);
            3'd2:    return NPH_W'(3);
            3'd3:    return NPH_W'(4);
            default: return NPH_W'(COM_MAX);
        endcase
    endfunction

    function automatic bias_e bias_decode(logic [1:0] b);
        case (b)
            2'd0:    return BIAS_2;
            2'd1:    return BIAS_3;
            default: return BIAS_4;
        endcase
    endfunction

    function automatic lvl_e com_level(drv_ctx_t c, logic [NPH_W-1:0] idx);
        if (idx >= c.nph)
            return LV_GND;
        if (idx == NPH_W'(c.phase))
            return c.odd ? LV_FULL : LV_GND;
        case (c.bias)
            BIAS_2:  return LV_HALF;
            BIAS_3:  return c.odd ? LV_T1 : LV_T2;
            default: return c.odd ? LV_Q1 : LV_Q3;
        endcase
    endfunction

    function automatic lvl_e seg_level(drv_ctx_t c, logic lit);
        if (lit)
            return c.odd ? LV_GND : LV_FULL;
        if (c.nph == NPH_W'(1))
            return c.odd ? LV_FULL : LV_GND;
        case (c.bias)
            BIAS_3:  return c.odd ? LV_T2 : LV_T1;
            default: return LV_HALF;
        endcase
    endfunction

endpackage

// File: rtl/lcd_phase_ctrl.sv
module lcd_phase_ctrl
    import lcd_lvl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       phase_tick,
    input  logic [2:0] duty_sel,
    input  logic [1:0] bias_sel,
    output logic       upd,
    output logic       running,
    output drv_ctx_t   ctx_nxt
);

    logic [PH_W-1:0]  phase_q;
    logic             odd_q;
    logic             run_q;
    logic [NPH_W-1:0] nph_q;
    bias_e            bias_q;
    logic             at_last;

    assign upd     = en & phase_tick;
    assign running = run_q;
    assign at_last = (NPH_W'(phase_q) == (nph_q - NPH_W'(1)));

    always_comb begin
        ctx_nxt.phase = phase_q;
        ctx_nxt.odd   = odd_q;
        ctx_nxt.nph   = nph_q;
        ctx_nxt.bias  = bias_q;
        if (!run_q) begin
            ctx_nxt.phase = '0;
            ctx_nxt.odd   = 1'b1;
            ctx_nxt.nph   = duty_phases(duty_sel);
            ctx_nxt.bias  = bias_decode(bias_sel);
        end else if (at_last) begin
            ctx_nxt.phase = '0;
            ctx_nxt.odd   = ~odd_q;
            ctx_nxt.nph   = duty_phases(duty_sel);
            ctx_nxt.bias  = bias_decode(bias_sel);
        end else begin
            ctx_nxt.phase = phase_q + PH_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase_q <= '0;
            odd_q   <= 1'b1;
            run_q   <= 1'b0;
            nph_q   <= NPH_W'(1);
            bias_q  <= BIAS_2;
        end else if (upd) begin
            phase_q <= ctx_nxt.phase;
            odd_q   <= ctx_nxt.odd;
            run_q   <= 1'b1;
            nph_q   <= ctx_nxt.nph;
            bias_q  <= ctx_nxt.bias;
        end
    end

endmodule

// File: rtl/lcd_com_drv.sv
module lcd_com_drv
    import lcd_lvl_pkg::*;
(
    input  drv_ctx_t                         ctx,
    output logic [COM_MAX-1:0][LVL_W-1:0]    lvl
);

    for (genvar g = 0; g < COM_MAX; g++) begin : g_com
        assign lvl[g] = com_level(ctx, NPH_W'(g));
    end

endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv
    import lcd_lvl_pkg::*;
#(
    parameter int NUM_SEG = 8
) (
    input  drv_ctx_t                         ctx,
    input  logic [COM_MAX*NUM_SEG-1:0]       pix,
    output logic [NUM_SEG-1:0][LVL_W-1:0]    lvl
);

    logic [NUM_SEG-1:0] rows [COM_MAX];
    logic [NUM_SEG-1:0] row;

    for (genvar c = 0; c < COM_MAX; c++) begin : g_row
        assign rows[c] = pix[c*NUM_SEG +: NUM_SEG];
    end

    assign row = rows[ctx.phase];

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        assign lvl[s] = seg_level(ctx, row[s]);
    end

endmodule

// File: rtl/lcd_mux_drive.sv
module lcd_mux_drive
    import lcd_lvl_pkg::*;
#(
    parameter int NUM_SEG = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    input  logic                         phase_tick,
    input  logic [2:0]                   duty_sel,
    input  logic [1:0]                   bias_sel,
    input  logic [COM_MAX*NUM_SEG-1:0]   pix,
    output logic [COM_MAX*LVL_W-1:0]     com_lvl,
    output logic [NUM_SEG*LVL_W-1:0]     seg_lvl,
    output logic                         en_stat
);

    logic                               upd;
    logic                               running;
    drv_ctx_t                           ctx_nxt;
    logic [COM_MAX-1:0][LVL_W-1:0]      com_d;
    logic [NUM_SEG-1:0][LVL_W-1:0]      seg_d;
    logic [COM_MAX-1:0][LVL_W-1:0]      com_q;
    logic [NUM_SEG-1:0][LVL_W-1:0]      seg_q;

    lcd_phase_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .phase_tick (phase_tick),
        .duty_sel   (duty_sel),
        .bias_sel   (bias_sel),
        .upd        (upd),
        .running    (running),
        .ctx_nxt    (ctx_nxt)
    );

    lcd_com_drv u_com (
        .ctx (ctx_nxt),
        .lvl (com_d)
    );

    lcd_seg_drv #(.NUM_SEG(NUM_SEG)) u_seg (
        .ctx (ctx_nxt),
        .pix (pix),
        .lvl (seg_d)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            com_q <= '0;
            seg_q <= '0;
        end else if (upd) begin
            com_q <= com_d;
            seg_q <= seg_d;
        end
    end

    assign com_lvl = com_q;
    assign seg_lvl = seg_q;
    assign en_stat = running & en;

endmodule

// File: rtl/lcd_mux_drive_chk.sv
module lcd_mux_drive_chk
    import lcd_lvl_pkg::*;
#(
    parameter int NUM_SEG = 8
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         en,
    input logic                         phase_tick,
    input logic [COM_MAX*LVL_W-1:0]     com_lvl,
    input logic [NUM_SEG*LVL_W-1:0]     seg_lvl,
    input logic                         en_stat
);

    logic [COM_MAX-1:0] full_vec;
    logic               bad_code;

    always_comb begin
        bad_code = 1'b0;
        for (int c = 0; c < COM_MAX; c++) begin
            full_vec[c] = (com_lvl[c*LVL_W +: LVL_W] == 3'd6);
            if (com_lvl[c*LVL_W +: LVL_W] > 3'd6) bad_code = 1'b1;
        end
        for (int s = 0; s < NUM_SEG; s++) begin
            if (seg_lvl[s*LVL_W +: LVL_W] > 3'd6) bad_code = 1'b1;
        end
    end

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst) !bad_code); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) (en && !phase_tick) |=> ($stable(com_lvl) && $stable(seg_lvl))); // R4
    AST_ONE_FULL: assert property (@(posedge clk) disable iff (rst) $countones(full_vec) <= 1); // R5
    AST_DIS_GROUND: assert property (@(posedge clk) disable iff (rst) !en |=> (com_lvl == '0 && seg_lvl == '0)); // R2
    AST_STAT_OFF: assert property (@(posedge clk) disable iff (rst) !en |-> !en_stat); // R2
    AST_STAT_RISE: assert property (@(posedge clk) disable iff (rst) $rose(en_stat) |-> $past(phase_tick)); // R3

endmodule

bind lcd_mux_drive lcd_mux_drive_chk #(.NUM_SEG(NUM_SEG)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .phase_tick (phase_tick),
    .com_lvl    (com_lvl),
    .seg_lvl    (seg_lvl),
    .en_stat    (en_stat)
);

// File: tb/sim_lcd_mux_drive.sv
`timescale 1ns/1ps
module sim_lcd_mux_drive;

    localparam int NS  = 8;
    localparam int NC  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              d_en = 1'b0;
    logic              d_tick = 1'b0;
    logic [2:0]        d_duty = 3'd0;
    logic [1:0]        d_bias = 2'd0;
    logic [NC*NS-1:0]  d_pix = '0;
    logic [NC*3-1:0]   com_lvl;
    logic [NS*3-1:0]   seg_lvl;
    logic              en_stat;

    int n_chk  = 0;
    int n_fail = 0;

    // bench model state
    bit m_run;
    int m_phase, m_nph, m_bias;
    bit m_odd;
    int exp_com [NC];
    int exp_seg [NS];
    bit exp_lit [NS];

    always #10 clk = ~clk;

    lcd_mux_drive #(.NUM_SEG(NS)) u0 (
        .clk(clk), .rst(rst), .en(d_en), .phase_tick(d_tick),
        .duty_sel(d_duty), .bias_sel(d_bias), .pix(d_pix),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl), .en_stat(en_stat)
    );

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    // R8 phase count per duty code
    function automatic int b_count(logic [2:0] d);
        case (d) 0: return 1; 1: return 2; 2: return 3; 3: return 4; default: return 8; endcase
    endfunction

    // R6 bias code: 0 half, 1 third, else quarter
    function automatic int b_biasn(logic [1:0] b);
        return (b == 0) ? 2 : (b == 1) ? 3 : 4;
    endfunction

    function automatic int b_com(int c);
        if (c >= m_nph) return 0;                // R7
        if (c == m_phase) return m_odd ? 6 : 0;  // R5
        if (m_bias == 2) return 3;               // R6
        if (m_bias == 3) return m_odd ? 2 : 4;
        return m_odd ? 1 : 5;
    endfunction

    function automatic int b_seg(bit lit);
        if (lit) return m_odd ? 0 : 6;           // R9
        if (m_nph == 1) return m_odd ? 6 : 0;    // R10
        if (m_bias == 3) return m_odd ? 4 : 2;
        return 3;
    endfunction

    task automatic chk(string tag, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        if (!d_en) begin
            m_run = 0; m_phase = 0; m_odd = 1;
            for (int c = 0; c < NC; c++) exp_com[c] = 0;
            for (int s = 0; s < NS; s++) begin exp_seg[s] = 0; exp_lit[s] = 0; end
        end else if (d_tick) begin
            if (!m_run) begin
                m_run = 1; m_phase = 0; m_odd = 1;
                m_nph = b_count(d_duty); m_bias = b_biasn(d_bias);
            end else if (m_phase == m_nph - 1) begin
                m_phase = 0; m_odd = !m_odd;
                m_nph = b_count(d_duty); m_bias = b_biasn(d_bias); // R11
            end else begin
                m_phase++;
            end
            for (int c = 0; c < NC; c++) exp_com[c] = b_com(c);
            for (int s = 0; s < NS; s++) begin
                exp_lit[s] = d_pix[m_phase*NS + s];
                exp_seg[s] = b_seg(exp_lit[s]);
            end
        end
    endtask

    task automatic compare_all();
        string t;
        chk(d_en ? "R3" : "R2", int'(en_stat), int'(m_run && d_en), "en_stat");
        for (int c = 0; c < NC; c++) begin
            if (!m_run) t = d_en ? "R3" : "R2";
            else if (c >= m_nph) t = "R7";
            else if (c == m_phase) t = "R5";
            else t = "R6";
            chk(t, int'(com_lvl[c*3 +: 3]), exp_com[c], $sformatf("com%0d", c));
        end
        for (int s = 0; s < NS; s++) begin
            if (!m_run) t = d_en ? "R3" : "R2";
            else t = exp_lit[s] ? "R9" : "R10";
            chk(t, int'(seg_lvl[s*3 +: 3]), exp_seg[s], $sformatf("seg%0d", s));
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    function automatic int com_at(int c);
        return int'(com_lvl[c*3 +: 3]);
    endfunction

    initial begin
        void'($urandom(32'h5EED_1CD0));
        m_run = 0; m_phase = 0; m_odd = 1; m_nph = 1; m_bias = 2;
        for (int c = 0; c < NC; c++) exp_com[c] = 0;
        for (int s = 0; s < NS; s++) begin exp_seg[s] = 0; exp_lit[s] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", int'(en_stat), 0, "en_stat after reset");
        chk("R1", int'(com_lvl), 0, "com after reset");
        chk("R1", int'(seg_lvl), 0, "seg after reset");

        // R3 enabled but no tick yet
        d_en = 1; d_duty = 3'd3; d_bias = 2'd1; d_tick = 0;
        d_pix = 64'h0000_0000_0000_00A5;
        step();
        chk("R3", int'(en_stat), 0, "no tick yet");
        d_tick = 1;
        step();
        chk("R3", int'(en_stat), 1, "first tick");
        chk("R5", com_at(0), 6, "phase0 odd active");
        chk("R6", com_at(1), 2, "third bias odd inactive");
        chk("R7", com_at(4), 0, "unused line");
        chk("R9", int'(seg_lvl[2:0]), 0, "lit seg odd");
        chk("R10", int'(seg_lvl[5:3]), 4, "dark seg third odd");
        d_tick = 0;
        step();
        step(); // R4 hold without tick
        d_tick = 1;
        step(); // phase 1
        // R11 change config mid frame
        d_duty = 3'd1; d_bias = 2'd2;
        step(); // phase 2, old config
        chk("R11", com_at(2), 6, "old duty kept");
        chk("R11", com_at(1), 2, "old bias kept");
        step(); // phase 3
        step(); // wrap, even frame, new config
        chk("R8", com_at(0), 0, "wrap to even frame");
        chk("R11", com_at(1), 5, "new bias quarter even");
        chk("R11", com_at(2), 0, "new duty drops line 2");

        // R2 disable
        d_en = 0; d_tick = 0;
        step();
        chk("R2", int'(com_lvl), 0, "disabled commons");
        chk("R2", int'(en_stat), 0, "disabled status");

        // static duty
        d_en = 1; d_duty = 3'd0; d_tick = 1; d_pix = 64'h1;
        step();
        chk("R7", com_at(1), 0, "static upper line");
        chk("R9", int'(seg_lvl[2:0]), 0, "static lit odd");
        chk("R10", int'(seg_lvl[5:3]), 6, "static dark equals com");
        step();
        chk("R8", com_at(0), 0, "static toggles each tick");
        chk("R10", int'(seg_lvl[5:3]), 0, "static dark even");

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            d_en   = ($urandom % 40) != 0;
            d_tick = ($urandom % 2) == 0;
            if (($urandom % 25) == 0) d_duty = 3'($urandom);
            if (($urandom % 25) == 0) d_bias = 2'($urandom);
            d_pix  = {$urandom, $urandom};
            step();
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule